// File: doc/BRIEF.md
# Prioritised Interrupt Dispatch Unit

This block decides, cycle by cycle, whether the processor core takes an interrupt and which one. It holds a pending register that software sets and clears through write strobes, an enable mask, and a status word. The status word carries a current interrupt level, an exception-mode flag and a user-mode flag. Each interrupt line has a fixed level that is chosen by a parameter. Lines that are marked as timer lines become pending from timer request inputs and are cleared by a compare-write strobe.

When an interrupt is taken, the block pulses `take_o` and reports the vector select and the line number. Level-1 entries set the exception-mode flag and load a cause code. Entries at level 2 and above also save the old status word, raise the level field and set the exception-mode flag. The PC of the interrupted instruction is saved into a per-level save slot. The core drives one-cycle operation strobes for the following:
- writing the status word;
- setting the level while reading back the old status word;
- waiting for an interrupt with a stall;
- returning from a level, which restores the status word and redirects the PC;
- writing the save slots from software before a return.

Top module: `irq_dispatch`

## Requirements
- R1: A set strobe makes the masked software bits pending and a clear strobe removes them; if both name a bit in one cycle, clear wins. `pend_o` shows the result one cycle after the strobe.
- R2: An interrupt whose enable bit is 0 is never taken. Writing 0 to the enable register stops all delivery.
- R3: Status bits [3:0] hold the level, bit 4 the exception-mode flag and bit 5 the user-mode flag. A line of level L is taken only if it is pending, enabled and L is above the current level. A level-1 line is also not taken while the exception-mode flag is 1.
- R4: The level-set operation loads `old_ps_o` with the whole status word and writes its immediate into bits [3:0] only.
- R5: On a level-1 entry, status bit 4 is set, the level field is unchanged, `cause_o` becomes 4 and the PC is saved into save slot 1.
- R6: A level-1 entry gives `vec_o` = 0 (user vector) when status bit 5 was 1, and `vec_o` = 1 (kernel vector) when it was 0.
- R7: The highest-level eligible line wins. Among eligible lines of equal level, the lowest-numbered bit wins.
- R8: On an entry at level N ≥ 2:
  - the old status word goes to save slot N and the PC to save slot N;
  - the new status word is (old & ~0x1F) | 0x10 | N;
  - `vec_o` = N.
- R9: A return for level N (1..MAX_LVL) loads the status word from save slot N. It also pulses `redirect_o`, with `redirect_pc_o` equal to the PC in save slot N. Software can write both slots, and can read them back through `rd_lvl`.
- R10: The wait operation writes its immediate into bits [3:0] and raises `stall_o`. `stall_o` stays high until an interrupt is taken, and it falls in that same cycle.
- R11: Taking an interrupt leaves its pending bit set. A take squashes any status operation in the same cycle (status write, level set, wait, return).
- R12: Timer-type bits ignore the set and clear strobes. A request input makes the bit pending, and its compare strobe clears it, with the compare strobe winning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_we | input | 1 | Pending set strobe |
| set_mask | input | NUM_IRQ | Bits to make pending |
| clr_we | input | 1 | Pending clear strobe |
| clr_mask | input | NUM_IRQ | Bits to clear |
| tmr_req | input | NUM_IRQ | Timer request per line |
| tmr_clr | input | NUM_IRQ | Timer compare-write strobe per line |
| en_we | input | 1 | Enable write strobe |
| en_data | input | NUM_IRQ | New enable mask |
| ps_we | input | 1 | Status write strobe |
| ps_wdata | input | XLEN | New status word |
| lvl_set | input | 1 | Level-set-and-read strobe |
| lvl_imm | input | 4 | Level for the level-set operation |
| wait_go | input | 1 | Wait-for-interrupt strobe |
| wait_imm | input | 4 | Level for the wait operation |
| rfi_go | input | 1 | Return strobe |
| rfi_lvl | input | 4 | Level to return from |
| save_we | input | 1 | Save slot write strobe |
| save_lvl | input | 4 | Save slot level |
| save_is_pc | input | 1 | 1 writes the PC slot, 0 writes the status slot |
| save_data | input | XLEN | Save slot write data |
| rd_lvl | input | 4 | Save slot read level |
| cur_pc | input | XLEN | PC of the current instruction |
| pend_o | output | NUM_IRQ | Pending register |
| en_o | output | NUM_IRQ | Enable register |
| ps_o | output | XLEN | Status word |
| old_ps_o | output | XLEN | Status word returned by the level-set operation |
| cause_o | output | CAUSE_W | Cause code |
| stall_o | output | 1 | Core stalled by the wait operation |
| take_o | output | 1 | One-cycle pulse when an interrupt is taken |
| vec_o | output | 4 | Vector select of the last take |
| irq_id_o | output | ID_W | Line number of the last take |
| redirect_o | output | 1 | One-cycle return pulse |
| redirect_pc_o | output | XLEN | Return target PC |
| rd_ps_o | output | XLEN | Saved status word at `rd_lvl` (0 if out of range) |
| rd_pc_o | output | XLEN | Saved PC at `rd_lvl` (0 if out of range) |

## Verification
A wrong pending, enable or status bit shows up one cycle later. The symptom is a missing `take_o`, an extra `take_o`, or a wrong `irq_id_o`. A corrupted level or exception-mode bit shows at once on `ps_o`. It also changes which line is taken next, so the fault spreads to every later entry. A corrupt save slot stays hidden until it is read through `rd_lvl` or used by a return, where it shows as a wrong `redirect_pc_o` or restored status word. The bench model compares every port on every clock, so any such divergence is reported in the cycle it reaches a port.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int LVL_W    = 4;
  localparam int VEC_W    = LVL_W;
  localparam int EXCM_BIT = 4;
  localparam int USER_BIT = 5;
  localparam logic [VEC_W-1:0] VEC_USER   = 4'd0;
  localparam logic [VEC_W-1:0] VEC_KERNEL = 4'd1;
  localparam logic [LVL_W-1:0] LVL_ONE    = 4'd1;
  localparam int CAUSE_L1_VAL = 4;
endpackage

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int NUM_IRQ = 8,
  parameter logic [NUM_IRQ-1:0] TIMER_MASK = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               set_we,
  input  logic [NUM_IRQ-1:0] set_mask,
  input  logic               clr_we,
  input  logic [NUM_IRQ-1:0] clr_mask,
  input  logic [NUM_IRQ-1:0] tmr_req,
  input  logic [NUM_IRQ-1:0] tmr_clr,
  output logic [NUM_IRQ-1:0] pend
);
  logic [NUM_IRQ-1:0] sw_set, sw_clr, sw_next, tm_next;

  always_comb begin
    sw_set  = set_we ? set_mask : '0;
    sw_clr  = clr_we ? clr_mask : '0;
    // software lines: clear beats set
    sw_next = (pend | sw_set) & ~sw_clr & ~TIMER_MASK;
    // timer lines: compare write beats request
    tm_next = (pend | tmr_req) & ~tmr_clr & TIMER_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= sw_next | tm_next;
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter logic [NUM_IRQ*LVL_W-1:0] LVL_MAP = '0,
  localparam int ID_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic [NUM_IRQ-1:0] pend,
  input  logic [NUM_IRQ-1:0] en,
  input  logic [LVL_W-1:0]   cur_lvl,
  input  logic               excm,
  output logic               found,
  output logic [ID_W-1:0]    win_id,
  output logic [LVL_W-1:0]   win_lvl
);
  logic [LVL_W-1:0] line_lvl;
  logic             eligible;

  // Ascending scan with a strict "greater" test: highest level wins,
  // the lowest index wins among equals.
  always_comb begin
    found    = 1'b0;
    win_id   = '0;
    win_lvl  = '0;
    line_lvl = '0;
    eligible = 1'b0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      line_lvl = LVL_MAP[i*LVL_W +: LVL_W];
      eligible = pend[i] && en[i] && (line_lvl > cur_lvl) &&
                 !(line_lvl == LVL_ONE && excm);
      if (eligible && line_lvl > win_lvl) begin
        found   = 1'b1;
        win_id  = ID_W'(i);
        win_lvl = line_lvl;
      end
    end
  end
endmodule

// File: rtl/irq_save_bank.sv
module irq_save_bank
  import irq_pkg::*;
#(
  parameter int MAX_LVL = 6,
  parameter int XLEN    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take_we,
  input  logic [LVL_W-1:0] take_lvl,
  input  logic [XLEN-1:0]  take_ps,
  input  logic [XLEN-1:0]  take_pc,
  input  logic             sw_we,
  input  logic [LVL_W-1:0] sw_lvl,
  input  logic             sw_is_pc,
  input  logic [XLEN-1:0]  sw_data,
  input  logic [LVL_W-1:0] rd_lvl,
  input  logic [LVL_W-1:0] ret_lvl,
  output logic [XLEN-1:0]  rd_ps,
  output logic [XLEN-1:0]  rd_pc,
  output logic [XLEN-1:0]  ret_ps,
  output logic [XLEN-1:0]  ret_pc
);
  logic [XLEN-1:0] ps_mem [1:MAX_LVL];
  logic [XLEN-1:0] pc_mem [1:MAX_LVL];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int n = 1; n <= MAX_LVL; n++) begin
        ps_mem[n] <= '0;
        pc_mem[n] <= '0;
      end
    end else begin
      for (int n = 1; n <= MAX_LVL; n++) begin
        if (take_we && take_lvl == LVL_W'(n)) begin
          pc_mem[n] <= take_pc;
          if (n >= 2) ps_mem[n] <= take_ps;
        end else if (sw_we && sw_lvl == LVL_W'(n)) begin
          if (sw_is_pc) pc_mem[n] <= sw_data;
          else          ps_mem[n] <= sw_data;
        end
      end
    end
  end

  always_comb begin
    rd_ps  = '0;
    rd_pc  = '0;
    ret_ps = '0;
    ret_pc = '0;
    for (int n = 1; n <= MAX_LVL; n++) begin
      if (rd_lvl == LVL_W'(n)) begin
        rd_ps = ps_mem[n];
        rd_pc = pc_mem[n];
      end
      if (ret_lvl == LVL_W'(n)) begin
        ret_ps = ps_mem[n];
        ret_pc = pc_mem[n];
      end
    end
  end
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
  import irq_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int XLEN    = 32,
  parameter int MAX_LVL = 6,
  parameter int CAUSE_W = 6,
  parameter logic [NUM_IRQ*LVL_W-1:0] LVL_MAP = 32'h6141_3211,
  parameter logic [NUM_IRQ-1:0] TIMER_MASK = 8'b0001_0000,
  localparam int ID_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               set_we,
  input  logic [NUM_IRQ-1:0] set_mask,
  input  logic               clr_we,
  input  logic [NUM_IRQ-1:0] clr_mask,
  input  logic [NUM_IRQ-1:0] tmr_req,
  input  logic [NUM_IRQ-1:0] tmr_clr,
  input  logic               en_we,
  input  logic [NUM_IRQ-1:0] en_data,
  input  logic               ps_we,
  input  logic [XLEN-1:0]    ps_wdata,
  input  logic               lvl_set,
  input  logic [LVL_W-1:0]   lvl_imm,
  input  logic               wait_go,
  input  logic [LVL_W-1:0]   wait_imm,
  input  logic               rfi_go,
  input  logic [LVL_W-1:0]   rfi_lvl,
  input  logic               save_we,
  input  logic [LVL_W-1:0]   save_lvl,
  input  logic               save_is_pc,
  input  logic [XLEN-1:0]    save_data,
  input  logic [LVL_W-1:0]   rd_lvl,
  input  logic [XLEN-1:0]    cur_pc,
  output logic [NUM_IRQ-1:0] pend_o,
  output logic [NUM_IRQ-1:0] en_o,
  output logic [XLEN-1:0]    ps_o,
  output logic [XLEN-1:0]    old_ps_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               stall_o,
  output logic               take_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic [ID_W-1:0]    irq_id_o,
  output logic               redirect_o,
  output logic [XLEN-1:0]    redirect_pc_o,
  output logic [XLEN-1:0]    rd_ps_o,
  output logic [XLEN-1:0]    rd_pc_o
);
  logic             found;
  logic [ID_W-1:0]  win_id;
  logic [LVL_W-1:0] win_lvl;
  logic [XLEN-1:0]  ps_take, ret_ps, ret_pc;
  logic             rfi_ok;

  irq_pending #(.NUM_IRQ(NUM_IRQ), .TIMER_MASK(TIMER_MASK)) u_pend (
    .clk(clk), .rst(rst),
    .set_we(set_we), .set_mask(set_mask),
    .clr_we(clr_we), .clr_mask(clr_mask),
    .tmr_req(tmr_req), .tmr_clr(tmr_clr),
    .pend(pend_o)
  );

  irq_arbiter #(.NUM_IRQ(NUM_IRQ), .LVL_MAP(LVL_MAP)) u_arb (
    .pend(pend_o), .en(en_o),
    .cur_lvl(ps_o[LVL_W-1:0]), .excm(ps_o[EXCM_BIT]),
    .found(found), .win_id(win_id), .win_lvl(win_lvl)
  );

  irq_save_bank #(.MAX_LVL(MAX_LVL), .XLEN(XLEN)) u_save (
    .clk(clk), .rst(rst),
    .take_we(found), .take_lvl(win_lvl), .take_ps(ps_o), .take_pc(cur_pc),
    .sw_we(save_we), .sw_lvl(save_lvl), .sw_is_pc(save_is_pc), .sw_data(save_data),
    .rd_lvl(rd_lvl), .ret_lvl(rfi_lvl),
    .rd_ps(rd_ps_o), .rd_pc(rd_pc_o), .ret_ps(ret_ps), .ret_pc(ret_pc)
  );

  always_comb begin
    rfi_ok = rfi_go && (rfi_lvl != '0) && (rfi_lvl <= LVL_W'(MAX_LVL));
    if (win_lvl == LVL_ONE) begin
      ps_take = ps_o;
      ps_take[EXCM_BIT] = 1'b1;
    end else begin
      ps_take = {ps_o[XLEN-1:EXCM_BIT+1], 1'b1, win_lvl};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_o          <= '0;
      ps_o          <= '0;
      old_ps_o      <= '0;
      cause_o       <= '0;
      stall_o       <= 1'b0;
      take_o        <= 1'b0;
      vec_o         <= '0;
      irq_id_o      <= '0;
      redirect_o    <= 1'b0;
      redirect_pc_o <= '0;
    end else begin
      take_o     <= found;
      redirect_o <= 1'b0;
      if (en_we) en_o <= en_data;
      if (found) begin
        ps_o     <= ps_take;
        stall_o  <= 1'b0;
        irq_id_o <= win_id;
        if (win_lvl == LVL_ONE) begin
          vec_o   <= ps_o[USER_BIT] ? VEC_USER : VEC_KERNEL;
          cause_o <= CAUSE_W'(CAUSE_L1_VAL);
        end else begin
          vec_o <= win_lvl;
        end
      end else if (rfi_ok) begin
        ps_o          <= ret_ps;
        redirect_o    <= 1'b1;
        redirect_pc_o <= ret_pc;
      end else if (wait_go) begin
        ps_o[LVL_W-1:0] <= wait_imm;
        stall_o         <= 1'b1;
      end else if (lvl_set) begin
        old_ps_o        <= ps_o;
        ps_o[LVL_W-1:0] <= lvl_imm;
      end else if (ps_we) begin
        ps_o <= ps_wdata;
      end
    end
  end
endmodule

// File: rtl/irq_dispatch_chk.sv
module irq_dispatch_chk
  import irq_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 6,
  parameter logic [NUM_IRQ*LVL_W-1:0] LVL_MAP = '0,
  localparam int ID_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_IRQ-1:0] pend_o,
  input logic [NUM_IRQ-1:0] en_o,
  input logic [XLEN-1:0]    ps_o,
  input logic [CAUSE_W-1:0] cause_o,
  input logic               stall_o,
  input logic               take_o,
  input logic [VEC_W-1:0]   vec_o,
  input logic [ID_W-1:0]    irq_id_o
);
  logic [NUM_IRQ-1:0] qual_prev;
  logic [XLEN-1:0]    ps_prev;
  logic [LVL_W-1:0]   id_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      qual_prev <= '0;
      ps_prev   <= '0;
    end else begin
      qual_prev <= pend_o & en_o;
      ps_prev   <= ps_o;
    end
  end

  always_comb begin
    id_lvl = '0;
    for (int i = 0; i < NUM_IRQ; i++)
      if (irq_id_o == ID_W'(i)) id_lvl = LVL_MAP[i*LVL_W +: LVL_W];
  end

  assert_take_enabled_R2: assert property (@(posedge clk) disable iff (rst)
    take_o |-> qual_prev[irq_id_o]);

  assert_level_above_R3: assert property (@(posedge clk) disable iff (rst)
    take_o |-> (id_lvl > ps_prev[LVL_W-1:0]));

  assert_l1_excm_mask_R3: assert property (@(posedge clk) disable iff (rst)
    (take_o && id_lvl == LVL_ONE) |-> !ps_prev[EXCM_BIT]);

  assert_l1_entry_R5: assert property (@(posedge clk) disable iff (rst)
    (take_o && id_lvl == LVL_ONE) |->
      (cause_o == CAUSE_W'(CAUSE_L1_VAL) && ps_o[EXCM_BIT] &&
       ps_o[LVL_W-1:0] == ps_prev[LVL_W-1:0]));

  assert_high_entry_R8: assert property (@(posedge clk) disable iff (rst)
    (take_o && id_lvl > LVL_ONE) |->
      (ps_o[EXCM_BIT] && ps_o[LVL_W-1:0] == id_lvl && vec_o == id_lvl));

  assert_stall_release_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(stall_o) |-> take_o);
endmodule

bind irq_dispatch irq_dispatch_chk #(
  .NUM_IRQ(NUM_IRQ), .XLEN(XLEN), .CAUSE_W(CAUSE_W), .LVL_MAP(LVL_MAP)
) u_chk (
  .clk(clk), .rst(rst), .pend_o(pend_o), .en_o(en_o), .ps_o(ps_o),
  .cause_o(cause_o), .stall_o(stall_o), .take_o(take_o), .vec_o(vec_o),
  .irq_id_o(irq_id_o)
);

// File: tb/tb_irq_dispatch.sv
module tb_irq_dispatch;
  localparam int NI = 8;
  localparam int ML = 6;
  localparam logic [31:0] LMAP  = 32'h6141_3211;
  localparam logic [7:0]  TMASK = 8'b0001_0000;

  logic clk = 0, rst = 1;
  always #2 clk = ~clk;

  logic set_we = 0, clr_we = 0, en_we = 0, ps_we = 0, lvl_set = 0, wait_go = 0;
  logic rfi_go = 0, save_we = 0, save_is_pc = 0;
  logic [7:0] set_mask = 0, clr_mask = 0, tmr_req = 0, tmr_clr = 0, en_data = 0;
  logic [31:0] ps_wdata = 0, save_data = 0, cur_pc = 32'h1000;
  logic [3:0] lvl_imm = 0, wait_imm = 0, rfi_lvl = 0, save_lvl = 0, rd_lvl = 1;

  logic [7:0] pend_o, en_o;
  logic [31:0] ps_o, old_ps_o, redirect_pc_o, rd_ps_o, rd_pc_o;
  logic [5:0] cause_o;
  logic stall_o, take_o, redirect_o;
  logic [3:0] vec_o;
  logic [2:0] irq_id_o;

  irq_dispatch #(.NUM_IRQ(NI), .XLEN(32), .MAX_LVL(ML), .CAUSE_W(6),
                 .LVL_MAP(LMAP), .TIMER_MASK(TMASK)) dut (
    .clk(clk), .rst(rst), .set_we(set_we), .set_mask(set_mask),
    .clr_we(clr_we), .clr_mask(clr_mask), .tmr_req(tmr_req), .tmr_clr(tmr_clr),
    .en_we(en_we), .en_data(en_data), .ps_we(ps_we), .ps_wdata(ps_wdata),
    .lvl_set(lvl_set), .lvl_imm(lvl_imm), .wait_go(wait_go), .wait_imm(wait_imm),
    .rfi_go(rfi_go), .rfi_lvl(rfi_lvl), .save_we(save_we), .save_lvl(save_lvl),
    .save_is_pc(save_is_pc), .save_data(save_data), .rd_lvl(rd_lvl), .cur_pc(cur_pc),
    .pend_o(pend_o), .en_o(en_o), .ps_o(ps_o), .old_ps_o(old_ps_o),
    .cause_o(cause_o), .stall_o(stall_o), .take_o(take_o), .vec_o(vec_o),
    .irq_id_o(irq_id_o), .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o),
    .rd_ps_o(rd_ps_o), .rd_pc_o(rd_pc_o)
  );

  int n_chk = 0, n_bad = 0, n_takes = 0, n_redir = 0;
  bit done = 0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int lvl_of(input int i);
    return int'(LMAP[i*4 +: 4]);
  endfunction

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_pend, m_en, np;
  logic [31:0] m_ps, m_old, m_rpc;
  logic [5:0] m_cause;
  logic m_stall, m_take, m_redir;
  logic [3:0] m_vec;
  logic [2:0] m_id;
  logic [31:0] m_eps [1:ML];
  logic [31:0] m_epc [1:ML];

  always @(posedge clk) begin
    int wid, wl;
    if (rst) begin
      m_pend = 0; m_en = 0; m_ps = 0; m_old = 0; m_rpc = 0; m_cause = 0;
      m_stall = 0; m_take = 0; m_redir = 0; m_vec = 0; m_id = 0;
      for (int n = 1; n <= ML; n++) begin m_eps[n] = 0; m_epc[n] = 0; end
    end else begin
      wid = -1; wl = 0;
      for (int L = ML; L >= 1; L--) begin
        if (wid < 0 && L > int'(m_ps[3:0]) && !(L == 1 && m_ps[4]))
          for (int i = 0; i < NI; i++)
            if (wid < 0 && m_pend[i] && m_en[i] && lvl_of(i) == L) begin wid = i; wl = L; end
      end
      np = m_pend;
      for (int i = 0; i < NI; i++) begin
        if (TMASK[i]) begin
          if (tmr_clr[i]) np[i] = 0; else if (tmr_req[i]) np[i] = 1;
        end else begin
          if (clr_we && clr_mask[i]) np[i] = 0; else if (set_we && set_mask[i]) np[i] = 1;
        end
      end
      m_take = (wid >= 0);
      m_redir = 0;
      if (save_we && save_lvl >= 1 && save_lvl <= ML && !(wid >= 0 && wl == int'(save_lvl))) begin
        if (save_is_pc) m_epc[save_lvl] = save_data; else m_eps[save_lvl] = save_data;
      end
      if (wid >= 0) begin
        m_id = wid[2:0]; m_stall = 0;
        m_epc[wl] = cur_pc;
        if (wl == 1) begin
          m_vec = m_ps[5] ? 4'd0 : 4'd1; m_cause = 6'd4; m_ps = m_ps | 32'h10;
        end else begin
          m_eps[wl] = m_ps; m_vec = wl[3:0];
          m_ps = (m_ps & ~32'h1f) | 32'h10 | wl;
        end
      end else if (rfi_go && rfi_lvl >= 1 && rfi_lvl <= ML) begin
        m_ps = m_eps[rfi_lvl]; m_redir = 1; m_rpc = m_epc[rfi_lvl];
      end else if (wait_go) begin
        m_ps[3:0] = wait_imm; m_stall = 1;
      end else if (lvl_set) begin
        m_old = m_ps; m_ps[3:0] = lvl_imm;
      end else if (ps_we) begin
        m_ps = ps_wdata;
      end
      if (en_we) m_en = en_data;
      m_pend = np;
    end
  end

  // per-clock comparison, 1 ns after the active edge
  always @(posedge clk) begin
    #1;
    if (!rst) begin
      chk("R1", "pend_o", 32'(pend_o), 32'(m_pend));
      chk("R2", "en_o", 32'(en_o), 32'(m_en));
      chk("R2", "take_o", 32'(take_o), 32'(m_take));
      chk("R3", "ps_o", ps_o, m_ps);
      chk("R4", "old_ps_o", old_ps_o, m_old);
      chk("R5", "cause_o", 32'(cause_o), 32'(m_cause));
      chk("R6", "vec_o", 32'(vec_o), 32'(m_vec));
      chk("R7", "irq_id_o", 32'(irq_id_o), 32'(m_id));
      chk("R9", "redirect_o", 32'(redirect_o), 32'(m_redir));
      chk("R9", "redirect_pc_o", redirect_pc_o, m_rpc);
      chk("R10", "stall_o", 32'(stall_o), 32'(m_stall));
      chk("R8", "rd_ps_o", rd_ps_o, (rd_lvl >= 1 && rd_lvl <= ML) ? m_eps[rd_lvl] : 32'h0);
      chk("R8", "rd_pc_o", rd_pc_o, (rd_lvl >= 1 && rd_lvl <= ML) ? m_epc[rd_lvl] : 32'h0);
      if (take_o) n_takes++;
      if (redirect_o) n_redir++;
    end
  end

  always @(negedge clk) cur_pc <= cur_pc + 4;

  // ---------------- stimulus helpers ----------------
  task automatic settle(input int n); repeat (n) @(negedge clk); endtask
  task automatic p_set(input logic [7:0] m);
    @(negedge clk); set_we = 1; set_mask = m; @(negedge clk); set_we = 0;
  endtask
  task automatic p_clr(input logic [7:0] m);
    @(negedge clk); clr_we = 1; clr_mask = m; @(negedge clk); clr_we = 0;
  endtask
  task automatic p_en(input logic [7:0] m);
    @(negedge clk); en_we = 1; en_data = m; @(negedge clk); en_we = 0;
  endtask
  task automatic p_ps(input logic [31:0] v);
    @(negedge clk); ps_we = 1; ps_wdata = v; @(negedge clk); ps_we = 0;
  endtask
  task automatic p_lvl(input logic [3:0] v);
    @(negedge clk); lvl_set = 1; lvl_imm = v; @(negedge clk); lvl_set = 0;
  endtask
  task automatic p_wait(input logic [3:0] v);
    @(negedge clk); wait_go = 1; wait_imm = v; @(negedge clk); wait_go = 0;
  endtask
  task automatic p_rfi(input logic [3:0] v);
    @(negedge clk); rfi_go = 1; rfi_lvl = v; @(negedge clk); rfi_go = 0;
  endtask
  task automatic p_save(input logic [3:0] l, input logic is_pc, input logic [31:0] d);
    @(negedge clk); save_we = 1; save_lvl = l; save_is_pc = is_pc; save_data = d;
    @(negedge clk); save_we = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    settle(1);
    chk("R3", "reset ps_o", ps_o, 32'h0);
    chk("R1", "reset pend_o", 32'(pend_o), 32'h0);
    chk("R10", "reset stall_o", 32'(stall_o), 32'h0);

    // R1 / R2: pending with enable 0 is never taken
    p_set(8'h01); settle(3);
    chk("R1", "pend after set", 32'(pend_o), 32'h01);
    chk("R2", "no take while disabled", n_takes, 0);
    p_clr(8'h01); settle(1);
    chk("R1", "pend after clear", 32'(pend_o), 32'h00);
    @(negedge clk); set_we = 1; clr_we = 1; set_mask = 8'h02; clr_mask = 8'h02;
    @(negedge clk); set_we = 0; clr_we = 0; settle(1);
    chk("R1", "clear wins over set", 32'(pend_o), 32'h00);

    // R12: timer line 4
    p_set(8'h10); settle(1);
    chk("R12", "set strobe ignored on timer bit", 32'(pend_o), 32'h00);
    @(negedge clk); tmr_req = 8'h10; @(negedge clk); tmr_req = 0; settle(1);
    chk("R12", "timer request pends", 32'(pend_o), 32'h10);
    p_clr(8'h10); settle(1);
    chk("R12", "clear strobe ignored on timer bit", 32'(pend_o), 32'h10);
    @(negedge clk); tmr_clr = 8'h10; tmr_req = 8'h10;
    @(negedge clk); tmr_clr = 0; tmr_req = 0; settle(1);
    chk("R12", "compare strobe clears", 32'(pend_o), 32'h00);

    // R5 / R6: level-1 kernel entry
    p_en(8'h01); p_set(8'h01); settle(3);
    chk("R5", "l1 take count", n_takes, 1);
    chk("R6", "kernel vector", 32'(vec_o), 32'h1);
    chk("R5", "cause", 32'(cause_o), 32'h4);
    chk("R5", "ps after l1", ps_o, 32'h10);
    chk("R11", "pending kept after take", 32'(pend_o), 32'h01);
    settle(4);
    chk("R3", "l1 masked by exception mode", n_takes, 1);

    // R6: user vector
    p_clr(8'h01); p_ps(32'h20); p_set(8'h01); settle(3);
    chk("R6", "user vector", 32'(vec_o), 32'h0);
    chk("R6", "ps after user entry", ps_o, 32'h30);

    // R2: enable cleared stops delivery
    p_en(8'h00); p_ps(32'h0); settle(4);
    chk("R2", "no take with enable 0", n_takes, 2);

    // R4: level set
    p_ps(32'h40025); p_lvl(4'd7); settle(1);
    chk("R4", "old status word", old_ps_o, 32'h40025);
    chk("R4", "level field only", ps_o, 32'h40027);

    // R7 / R8: priority by level, then by index
    p_clr(8'hFF); p_ps(32'h0); p_en(8'h0F); p_set(8'h0F); settle(3);
    chk("R7", "highest level first", 32'(irq_id_o), 32'd3);
    chk("R8", "ps on level 3 entry", ps_o, 32'h13);
    rd_lvl = 3; #1;
    chk("R8", "saved status level 3", rd_ps_o, 32'h0);
    p_clr(8'h08); p_rfi(4'd3); settle(3);
    chk("R9", "return pulses", n_redir, 1);
    chk("R7", "level 2 next", 32'(irq_id_o), 32'd2);
    chk("R8", "ps on level 2 entry", ps_o, 32'h12);
    p_clr(8'h04); p_rfi(4'd2); settle(3);
    chk("R7", "lowest bit among level 1", 32'(irq_id_o), 32'd0);
    chk("R5", "ps after l1 from zero", ps_o, 32'h10);

    // R9: software-written save slots
    p_clr(8'h0F); p_save(4'd5, 1'b0, 32'h40003); p_save(4'd5, 1'b1, 32'h2000);
    rd_lvl = 5; #1;
    chk("R9", "readback saved status", rd_ps_o, 32'h40003);
    chk("R9", "readback saved pc", rd_pc_o, 32'h2000);
    p_rfi(4'd5); settle(1);
    chk("R9", "status restored", ps_o, 32'h40003);
    chk("R9", "redirect target", redirect_pc_o, 32'h2000);

    // R10: wait stalls until a take
    p_ps(32'h0); p_en(8'h04); p_lvl(4'd5); p_wait(4'd0); settle(3);
    chk("R10", "stall held", 32'(stall_o), 32'h1);
    chk("R10", "wait level", 32'(ps_o[3:0]), 32'h0);
    p_set(8'h04); settle(3);
    chk("R10", "stall released", 32'(stall_o), 32'h0);
    chk("R10", "taken after wait", 32'(irq_id_o), 32'd2);

    // R11: a take squashes a status write in the same cycle
    p_en(8'h0C);
    @(negedge clk); set_we = 1; set_mask = 8'h08;
    @(negedge clk); set_we = 0; ps_we = 1; ps_wdata = 32'h0;
    @(negedge clk); ps_we = 0; settle(2);
    chk("R11", "status write squashed by take", ps_o, 32'h13);

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule